// File: doc/BRIEF.md
# Host Read Enable Gate with Running Checksum

This block decides whether a packet-based decoder may hand data packets to its host. It holds a 24-bit running checksum, seeded with the part identifier at reset. Every packet the host writes is XORed into that checksum, unless its ID is the checksum ID or falls in the ignored ID window. Each such write also closes the output path. The path opens again only when the host sends a checksum packet whose data equals the register. This shows that the host knows the XOR of everything it has sent.

While the path is closed, the block raises a request that tells the packet port to offer the part-identifier packet and nothing else. The port acknowledges with a one-cycle pulse once it has sent that packet. The gate only governs host reads. Decoding elsewhere in the chip runs on regardless. Packet framing is handled by the serial port in front of this block.

Top module: `csum_gate`

## Requirements
- R1: Reset leaves `out_en` low, `pid_req` high and the checksum register equal to the part-ID parameter (default 24'hA50F3C).
- R2: A strobed packet whose ID is neither 8'h00 nor in 8'h1C..8'h1F XORs its 24 data bits into the checksum register. It drives `out_en` low one clock later, even when the data are zero.
- R3: A strobed packet with ID 8'h00 arriving while `out_en` is low sets `out_en` high one clock later if its data equal the checksum register.
- R4: A strobed ID 8'h00 packet whose data differ from the register leaves `out_en` low and the register unchanged.
- R5: A strobed ID 8'h00 packet arriving while `out_en` is high changes nothing, whatever its data.
- R6: Strobed packets with IDs 8'h1C through 8'h1F change neither the register nor `out_en`.
- R7: `pid_req` goes high one clock after a data packet moves `out_en` from high to low, and on reset. It is not raised again by data packets that arrive while already disabled. A `pid_sent` pulse clears it one clock later, but a simultaneous entry into the disabled state wins.
- R8: `pid_req` drops in the same clock that `out_en` rises, and is never high while `out_en` is high.
- R9: With `rx_valid` low, the ID and data inputs have no effect on `out_en` or the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a complete host packet is present |
| rx_id | input | 8 | Packet ID field |
| rx_data | input | 24 | Packet data field |
| pid_sent | input | 1 | Pulse: the part-ID packet has gone to the host |
| out_en | output | 1 | High when data packets may be sent to the host |
| pid_req | output | 1 | Asks the packet port to offer the part-ID packet |

## Verification
Every result of this block is registered and appears exactly one rising edge after the strobe or acknowledge that causes it. No path takes two cycles. The bench drives each vector on a falling edge and compares `out_en` and `pid_req` on the next falling edge, so each check lands one edge after its stimulus. The register contents are never read directly. They are shown through the enable result of a later checksum packet carrying a computed XOR value, so mismatches and skipped IDs are proven untouched at the ports.

// File: rtl/csum_gate_pkg.sv
package csum_gate_pkg;
   typedef enum logic [1:0] {
      PK_DATA  = 2'd0,
      PK_CHECK = 2'd1,
      PK_SKIP  = 2'd2
   } pkt_class_e;
endpackage

// File: rtl/csum_classify.sv
module csum_classify
   import csum_gate_pkg::*;
#(
   parameter int unsigned ID_W     = 8,
   parameter int unsigned CHECK_ID = 0,
   parameter bit          SKIP_EN  = 1'b1,
   parameter int unsigned SKIP_LO  = 8'h1C,
   parameter int unsigned SKIP_HI  = 8'h1F
) (
   input  logic [ID_W-1:0] id,
   output pkt_class_e      cls
);
   localparam logic [ID_W-1:0] CHK = ID_W'(CHECK_ID);
   localparam logic [ID_W-1:0] LO  = ID_W'(SKIP_LO);
   localparam logic [ID_W-1:0] HI  = ID_W'(SKIP_HI);

   if (SKIP_EN && (SKIP_LO > SKIP_HI)) begin : g_bad_window
      $error("csum_classify: skip window is empty");
   end

   logic in_skip;

   if (SKIP_EN) begin : g_window
      assign in_skip = (id >= LO) && (id <= HI);
   end else begin : g_no_window
      assign in_skip = 1'b0;
   end

   always_comb begin
      if (id == CHK)    cls = PK_CHECK;
      else if (in_skip) cls = PK_SKIP;
      else              cls = PK_DATA;
   end
endmodule

// File: rtl/csum_accum.sv
module csum_accum #(
   parameter int unsigned          DATA_W = 24,
   parameter logic [DATA_W-1:0]    SEED   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= SEED;
      else if (upd) q <= q ^ din;
   end
endmodule

// File: rtl/csum_match.sv
module csum_match #(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned LANES  = 3
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic              eq
);
   localparam int unsigned LANE_W = DATA_W / LANES;

   if (LANES < 1 || (DATA_W % LANES) != 0) begin : g_bad_lanes
      $error("csum_match: LANES must divide DATA_W");
   end

   logic [LANES-1:0] lane_eq;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_eq[g] = (a[g*LANE_W +: LANE_W] == b[g*LANE_W +: LANE_W]);
   end

   assign eq = &lane_eq;
endmodule

// File: rtl/csum_gate.sv
module csum_gate
   import csum_gate_pkg::*;
#(
   parameter int unsigned       ID_W     = 8,
   parameter int unsigned       DATA_W   = 24,
   parameter logic [DATA_W-1:0] PART_ID  = 24'hA50F3C,
   parameter int unsigned       CHECK_ID = 0,
   parameter bit                SKIP_EN  = 1'b1,
   parameter int unsigned       SKIP_LO  = 8'h1C,
   parameter int unsigned       SKIP_HI  = 8'h1F,
   parameter int unsigned       LANES    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [ID_W-1:0]   rx_id,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              pid_sent,
   output logic              out_en,
   output logic              pid_req
);
   if (ID_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("csum_gate: widths must be positive");
   end
   if (CHECK_ID >= (1 << ID_W)) begin : g_bad_id
      $error("csum_gate: CHECK_ID does not fit ID_W");
   end

   pkt_class_e        cls;
   logic [DATA_W-1:0] csum_q;
   logic              match;
   logic              take_data;
   logic              take_chk;
   logic              open_now;
   logic              close_now;
   logic              en_q;
   logic              req_q;

   csum_classify #(
      .ID_W(ID_W), .CHECK_ID(CHECK_ID), .SKIP_EN(SKIP_EN),
      .SKIP_LO(SKIP_LO), .SKIP_HI(SKIP_HI)
   ) u_cls (
      .id (rx_id),
      .cls(cls)
   );

   csum_match #(.DATA_W(DATA_W), .LANES(LANES)) u_cmp (
      .a (csum_q),
      .b (rx_data),
      .eq(match)
   );

   assign take_data = rx_valid && (cls == PK_DATA);
   assign take_chk  = rx_valid && (cls == PK_CHECK) && !en_q;
   assign open_now  = take_chk && match;
   assign close_now = take_data && en_q;

   csum_accum #(.DATA_W(DATA_W), .SEED(PART_ID)) u_acc (
      .clk  (clk),
      .rst_n(rst_n),
      .upd  (take_data),
      .din  (rx_data),
      .q    (csum_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= 1'b0;
      else if (take_data) en_q <= 1'b0;
      else if (open_now)  en_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         req_q <= 1'b1;
      else if (close_now) req_q <= 1'b1;
      else if (open_now)  req_q <= 1'b0;
      else if (pid_sent)  req_q <= 1'b0;
   end

   assign out_en  = en_q;
   assign pid_req = req_q;
endmodule

// File: rtl/csum_gate_chk.sv
module csum_gate_chk #(
   parameter int unsigned ID_W     = 8,
   parameter int unsigned DATA_W   = 24,
   parameter int unsigned CHECK_ID = 0,
   parameter int unsigned SKIP_LO  = 8'h1C,
   parameter int unsigned SKIP_HI  = 8'h1F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic [ID_W-1:0]   rx_id,
   input logic [DATA_W-1:0] rx_data,
   input logic              pid_sent,
   input logic              out_en,
   input logic              pid_req,
   input logic [DATA_W-1:0] csum_q
);
   logic is_chk, is_skip, is_data;
   assign is_chk  = (rx_id == ID_W'(CHECK_ID));
   assign is_skip = (rx_id >= ID_W'(SKIP_LO)) && (rx_id <= ID_W'(SKIP_HI));
   assign is_data = !is_chk && !is_skip;

   a_r2_data_closes: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && is_data |=> !out_en);

   a_r2_data_folds: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && is_data |=> csum_q == ($past(csum_q) ^ $past(rx_data)));

   a_r4_mismatch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && is_chk && !out_en && (rx_data != csum_q) |=> !out_en && $stable(csum_q));

   a_r5_enabled_chk_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && is_chk && out_en |=> out_en && $stable(csum_q));

   a_r6_skip_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && is_skip |=> $stable(out_en) && $stable(csum_q));

   a_r7_req_on_close: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && is_data && out_en |=> pid_req);

   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      pid_sent && !(rx_valid && is_data && out_en) |=> !pid_req);

   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      out_en |-> !pid_req);

   a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(out_en) && $stable(csum_q));
endmodule

bind csum_gate csum_gate_chk #(
   .ID_W(ID_W), .DATA_W(DATA_W), .CHECK_ID(CHECK_ID),
   .SKIP_LO(SKIP_LO), .SKIP_HI(SKIP_HI)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rx_valid(rx_valid),
   .rx_id   (rx_id),
   .rx_data (rx_data),
   .pid_sent(pid_sent),
   .out_en  (out_en),
   .pid_req (pid_req),
   .csum_q  (csum_q)
);

// File: tb/tb_csum_gate.sv
module tb_csum_gate;
   localparam logic [23:0] PID = 24'hA50F3C;
   localparam int NV = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_id = '0;
   logic [23:0] rx_data = '0;
   logic        pid_sent = 1'b0;
   logic        out_en, pid_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   csum_gate #(.PART_ID(PID)) dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id),
      .rx_data(rx_data), .pid_sent(pid_sent), .out_en(out_en), .pid_req(pid_req)
   );

   // {valid, id, data, pid_sent, exp_en, exp_req}
   localparam logic [35:0] VEC [NV] = '{
      {1'b1, 8'h00, 24'h000000, 1'b0, 1'b0, 1'b1},  // R4 mismatch vs seed
      {1'b1, 8'h00, 24'hA50F3C, 1'b0, 1'b1, 1'b0},  // R3 R8 seed match
      {1'b1, 8'h00, 24'h000000, 1'b0, 1'b1, 1'b0},  // R5 ignored while open
      {1'b1, 8'h1D, 24'h123456, 1'b0, 1'b1, 1'b0},  // R6
      {1'b1, 8'h01, 24'h111111, 1'b0, 1'b0, 1'b1},  // R2 R7 csum=B41E2D
      {1'b0, 8'h00, 24'h000000, 1'b1, 1'b0, 1'b0},  // R7 ack clears
      {1'b1, 8'h80, 24'h0000FF, 1'b0, 1'b0, 1'b0},  // R7 no re-raise, csum=B41ED2
      {1'b1, 8'h00, 24'hB41E2D, 1'b0, 1'b0, 1'b0},  // R4 stale value
      {1'b1, 8'h1C, 24'hFFFFFF, 1'b0, 1'b0, 1'b0},  // R6
      {1'b1, 8'h00, 24'hB41ED2, 1'b0, 1'b1, 1'b0},  // R3 proves R4/R6 untouched
      {1'b0, 8'h01, 24'h999999, 1'b0, 1'b1, 1'b0},  // R9
      {1'b1, 8'h1F, 24'h000000, 1'b0, 1'b1, 1'b0},  // R6
      {1'b1, 8'h27, 24'h000001, 1'b1, 1'b0, 1'b1},  // R7 set wins, csum=B41ED3
      {1'b1, 8'h00, 24'hB41ED3, 1'b0, 1'b1, 1'b0}   // R3 R9 untouched
   };

   task automatic check(input string req, input logic en_e, input logic rq_e);
      n_chk++;
      if (out_en !== en_e || pid_req !== rq_e) begin
         n_fail++;
         $display("FAIL %s: out_en=%b pid_req=%b expected out_en=%b pid_req=%b",
                  req, out_en, pid_req, en_e, rq_e);
      end
   endtask

   task automatic send(input logic v, input logic [7:0] id, input logic [23:0] d,
                       input logic ps);
      rx_valid = v; rx_id = id; rx_data = d; pid_sent = ps;
      @(negedge clk);
      rx_valid = 1'b0; pid_sent = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", 1'b0, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 1'b0, 1'b1);

      for (int i = 0; i < NV; i++) begin
         send(VEC[i][35], VEC[i][34:27], VEC[i][26:3], VEC[i][2]);
         check($sformatf("R2-vector %0d", i), VEC[i][1], VEC[i][0]);
      end

      // R1: reset mid-run reloads the seed
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 async reset", 1'b0, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      send(1'b1, 8'h00, PID, 1'b0);
      check("R1 seed reloaded", 1'b1, 1'b0);

      // R2: zero data still closes the path
      send(1'b1, 8'h20, 24'h000000, 1'b0);
      check("R2 zero data closes", 1'b0, 1'b1);
      send(1'b1, 8'h00, PID, 1'b0);
      check("R3 zero fold leaves seed", 1'b1, 1'b0);

      // R8: ack while open does nothing harmful
      send(1'b0, 8'h00, 24'h0, 1'b1);
      check("R8 ack while open", 1'b1, 1'b0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (2000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: done=0 expected done=1");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule